// File: doc/BRIEF.md
# External Interrupt Controller with Drive-Protection

This block gathers four external interrupt sources for a control processor. There are two configurable interrupt pins, one non-maskable input and one power-stage protection input. Every input passes through a two-flop synchronizer. The block then compares each synchronized sample with the previous one to find edges.

Each configurable pin has its own control word. That word selects enable, priority level (high, level 1, or low, level 6), active edge, and whether the pin instead acts as plain general-purpose I/O. A detected edge latches a sticky pending flag. Software clears the flag by writing 1 to it. The flags drive two shared priority request lines toward the CPU. The non-maskable input produces a one-cycle request that no register can suppress.

A rising edge on the protection input immediately forces the timer and PWM output enables into high impedance. The high-impedance state stays until software clears the protection flag. The protection request to the CPU always uses the high level and is gated only by its own enable bit.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the request lines, `nmi_req_o` and `drv_hiz_o` are low, and both pin control words read 0.
- R2: A pin edge sets the pending flag (control bit 15) three clock edges after the pin changes. Control bit 2 selects the edge: 1 for rising, 0 for falling. An edge of the other direction sets nothing.
- R3: The pending flag is set even when the pin is disabled (bit 0 = 0), and no request is raised then. Setting bit 0 later raises the request while the flag is still set.
- R4: Control bit 1 picks the level of an enabled pending pin: 0 drives `irq_hi_o` (level 1), 1 drives `irq_lo_o` (level 6).
- R5: Writing a control word with bit 15 = 1 clears the pending flag. Writing bit 15 = 0 leaves the flag as it was.
- R6: When a clearing write and a newly detected edge fall in the same cycle, the flag ends up set.
- R7: With bit 3 = 1 the pin is general-purpose I/O, which has these effects:
  - Edges set no flag and raise no request.
  - Bit 6 reads the synchronized pin level.
  - Bit 4 drives `gpio_oe_o` and bit 5 drives `gpio_out_o`.
- R8: A rising edge on `nmi_i` gives `nmi_req_o` high for exactly one cycle, three clock edges after the input rises. No register write affects it.
- R9: A rising edge on `prot_i` sets the protection flag (bit 1 of the word at `ADDR_PROT`) and `drv_hiz_o` three edges later, whatever the mask. `irq_hi_o` follows only when bit 0 of that word is 1.
- R10: `drv_hiz_o` stays high after `prot_i` falls. It drops only after a write with bit 1 = 1 to the protection word.
- R11: A shared level line stays high until every enabled pending source on that level has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 2 | Configurable interrupt pins (index 0 at `ADDR_A`, index 1 at `ADDR_B`) |
| nmi_i | input | 1 | Non-maskable interrupt input |
| prot_i | input | 1 | Power-stage protection input, active high |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Word address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data (combinational, 0 when unselected) |
| irq_hi_o | output | 1 | High-priority (level 1) request |
| irq_lo_o | output | 1 | Low-priority (level 6) request |
| nmi_req_o | output | 1 | Non-maskable request pulse |
| drv_hiz_o | output | 1 | Forces timer/PWM outputs to high impedance |
| gpio_oe_o | output | 2 | Pin output enables in general-purpose mode |
| gpio_out_o | output | 2 | Pin output values in general-purpose mode |

## Verification
A software clear of a pending flag and a fresh edge on the same pin can land on the same clock edge. The bench provokes this by raising the pin and then timing a clearing write so that the write is active exactly on the third edge after the pin change. It judges the outcome by reading the flag back and requiring it to be set. A second collision is between two low-level sources that share one request line: the bench clears them one at a time and requires the line to stay high until the last one is gone.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int BIT_EN    = 0;
    localparam int BIT_LO    = 1;
    localparam int BIT_RISE  = 2;
    localparam int BIT_GPIO  = 3;
    localparam int BIT_DIR   = 4;
    localparam int BIT_DOUT  = 5;
    localparam int BIT_PIN   = 6;
    localparam int BIT_FLAG  = 15;
    localparam int BIT_PEN   = 0;
    localparam int BIT_PFLAG = 1;

    typedef struct packed {
        logic en;
        logic lo;
        logic rise;
        logic gpio;
        logic dir;
        logic dout;
        logic flag;
        logic prev;
    } pin_st_t;

    typedef struct packed {
        logic en;
        logic flag;
        logic prev;
    } prot_st_t;

    typedef struct packed {
        logic prev;
        logic pulse;
    } nmi_st_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/eirq_pin.sv
module eirq_pin
    import eirq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_s,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          req_hi,
    output logic          req_lo,
    output logic          gpio_oe,
    output logic          gpio_out
);
    pin_st_t st_d, st_q;
    logic    edge_hit;
    logic    unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d     = st_q;
        st_d.prev = pin_s;
        edge_hit = st_q.rise ? (pin_s & ~st_q.prev) : (~pin_s & st_q.prev);
        if (wr_en) begin
            st_d.en   = wdata[BIT_EN];
            st_d.lo   = wdata[BIT_LO];
            st_d.rise = wdata[BIT_RISE];
            st_d.gpio = wdata[BIT_GPIO];
            st_d.dir  = wdata[BIT_DIR];
            st_d.dout = wdata[BIT_DOUT];
            if (wdata[BIT_FLAG]) st_d.flag = 1'b0;
        end
        // a new edge outranks a clear in the same cycle
        if (edge_hit && !st_q.gpio) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata           = '0;
        rdata[BIT_EN]   = st_q.en;
        rdata[BIT_LO]   = st_q.lo;
        rdata[BIT_RISE] = st_q.rise;
        rdata[BIT_GPIO] = st_q.gpio;
        rdata[BIT_DIR]  = st_q.dir;
        rdata[BIT_DOUT] = st_q.dout;
        rdata[BIT_PIN]  = pin_s;
        rdata[BIT_FLAG] = st_q.flag;
    end

    assign req_hi   = st_q.flag & st_q.en & ~st_q.lo & ~st_q.gpio;
    assign req_lo   = st_q.flag & st_q.en &  st_q.lo & ~st_q.gpio;
    assign gpio_oe  = st_q.gpio & st_q.dir;
    assign gpio_out = st_q.dout;
endmodule

// File: rtl/eirq_prot.sv
module eirq_prot
    import eirq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prot_s,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          req,
    output logic          hiz
);
    prot_st_t st_d, st_q;
    logic     unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d      = st_q;
        st_d.prev = prot_s;
        if (wr_en) begin
            st_d.en = wdata[BIT_PEN];
            if (wdata[BIT_PFLAG]) st_d.flag = 1'b0;
        end
        if (prot_s && !st_q.prev) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata            = '0;
        rdata[BIT_PEN]   = st_q.en;
        rdata[BIT_PFLAG] = st_q.flag;
    end

    assign req = st_q.flag & st_q.en;
    assign hiz = st_q.flag;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int              DW          = 16,
    parameter int              AW          = 16,
    parameter int              SYNC_STAGES = 2,
    parameter logic [AW-1:0]   ADDR_A      = 16'h7070,
    parameter logic [AW-1:0]   ADDR_B      = 16'h7071,
    parameter logic [AW-1:0]   ADDR_PROT   = 16'h742C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ext_pin_i,
    input  logic          nmi_i,
    input  logic          prot_i,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_hi_o,
    output logic          irq_lo_o,
    output logic          nmi_req_o,
    output logic          drv_hiz_o,
    output logic [1:0]    gpio_oe_o,
    output logic [1:0]    gpio_out_o
);
    localparam int NPIN = 2;
    localparam int NIN  = NPIN + 2;

    logic [NIN-1:0]  in_s;
    logic [DW-1:0]   pin_rd [NPIN];
    logic [NPIN-1:0] pin_hit, pin_hi, pin_lo;
    logic [DW-1:0]   prot_rd;
    logic            prot_hit, prot_req;
    nmi_st_t         nmi_d, nmi_q;

    eirq_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({prot_i, nmi_i, ext_pin_i}),
        .dout (in_s)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        localparam logic [AW-1:0] MY_ADDR = (g == 0) ? ADDR_A : ADDR_B;
        assign pin_hit[g] = bus_sel_i && (bus_addr_i == MY_ADDR);
        eirq_pin #(.DW(DW)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (in_s[g]),
            .wr_en   (pin_hit[g] && bus_wr_i),
            .wdata   (bus_wdata_i),
            .rdata   (pin_rd[g]),
            .req_hi  (pin_hi[g]),
            .req_lo  (pin_lo[g]),
            .gpio_oe (gpio_oe_o[g]),
            .gpio_out(gpio_out_o[g])
        );
    end

    assign prot_hit = bus_sel_i && (bus_addr_i == ADDR_PROT);

    eirq_prot #(.DW(DW)) u_prot (
        .clk   (clk),
        .rst_n (rst_n),
        .prot_s(in_s[NPIN+1]),
        .wr_en (prot_hit && bus_wr_i),
        .wdata (bus_wdata_i),
        .rdata (prot_rd),
        .req   (prot_req),
        .hiz   (drv_hiz_o)
    );

    // non-maskable path: no register can touch it
    always_comb begin
        nmi_d.prev  = in_s[NPIN];
        nmi_d.pulse = in_s[NPIN] & ~nmi_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_q <= '0;
        else        nmi_q <= nmi_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NPIN; i++) begin
            if (pin_hit[i]) bus_rdata_o = pin_rd[i];
        end
        if (prot_hit) bus_rdata_o = prot_rd;
    end

    assign irq_hi_o  = (|pin_hi) | prot_req;
    assign irq_lo_o  = |pin_lo;
    assign nmi_req_o = nmi_q.pulse;
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
    parameter int            AW        = 16,
    parameter int            DW        = 16,
    parameter logic [AW-1:0] ADDR_PROT = 16'h742C
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel_i,
    input logic          bus_wr_i,
    input logic [AW-1:0] bus_addr_i,
    input logic [DW-1:0] bus_wdata_i,
    input logic          irq_hi_o,
    input logic          irq_lo_o,
    input logic          nmi_req_o,
    input logic          drv_hiz_o
);
    logic any_wr, prot_clr;
    assign any_wr   = bus_sel_i && bus_wr_i;
    assign prot_clr = any_wr && (bus_addr_i == ADDR_PROT) && bus_wdata_i[1];

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_hi_o && !irq_lo_o && !nmi_req_o && !drv_hiz_o));

    p_nmi_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o |=> !nmi_req_o);

    p_hiz_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_hiz_o && !prot_clr) |=> drv_hiz_o);

    p_lo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo_o && !any_wr) |=> irq_lo_o);

    p_hi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi_o && !any_wr) |=> irq_hi_o);
endmodule

bind ext_irq_ctrl eirq_checker #(.AW(AW), .DW(DW), .ADDR_PROT(ADDR_PROT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel_i  (bus_sel_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .irq_hi_o   (irq_hi_o),
    .irq_lo_o   (irq_lo_o),
    .nmi_req_o  (nmi_req_o),
    .drv_hiz_o  (drv_hiz_o)
);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
    localparam logic [15:0] A_A = 16'h7070;
    localparam logic [15:0] A_B = 16'h7071;
    localparam logic [15:0] A_P = 16'h742C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_i = 2'b00;
    logic        nmi_i = 1'b0, prot_i = 1'b0;
    logic        bus_sel_i = 1'b0, bus_wr_i = 1'b0;
    logic [15:0] bus_addr_i = '0, bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic        irq_hi_o, irq_lo_o, nmi_req_o, drv_hiz_o;
    logic [1:0]  gpio_oe_o, gpio_out_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ext_irq_ctrl u_dut (.*);

    typedef struct packed {
        logic [15:0] ctrl;
        logic        lvl0;
        logic        lvl1;
        logic        eflag;
        logic        ehi;
        logic        elo;
    } vec_t;

    // ctrl bits: 0 enable, 1 low level, 2 rising, 3 gpio
    localparam vec_t VEC [8] = '{
        '{16'h0005, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{16'h0007, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'h0004, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{16'h000D, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'h0003, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{16'h0005, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [15:0] d);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        #0.5;
        d = bus_rdata_o;
        bus_sel_i = 1'b0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        cyc(3);
        // R1: reset state
        check("R1 irq_hi", {15'd0, irq_hi_o}, 16'd0);
        check("R1 irq_lo", {15'd0, irq_lo_o}, 16'd0);
        check("R1 hiz/nmi", {14'd0, drv_hiz_o, nmi_req_o}, 16'd0);
        rd(A_A, r); check("R1 ctrl A", r, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        cyc(2);

        // table of vectors on pin 0: R2 R3 R4 R7
        foreach (VEC[i]) begin
            wr(A_A, VEC[i].ctrl);
            ext_pin_i[0] = VEC[i].lvl0;
            cyc(5);
            wr(A_A, VEC[i].ctrl | 16'h8000);
            ext_pin_i[0] = VEC[i].lvl1;
            cyc(5);
            rd(A_A, r);
            check($sformatf("R2 vec%0d flag", i), {15'd0, r[15]}, {15'd0, VEC[i].eflag});
            check($sformatf("R4 vec%0d hi", i), {15'd0, irq_hi_o}, {15'd0, VEC[i].ehi});
            check($sformatf("R4 vec%0d lo", i), {15'd0, irq_lo_o}, {15'd0, VEC[i].elo});
            wr(A_A, 16'h8000);
        end

        // R2 timing: rising edge visible on third edge, not second
        ext_pin_i[0] = 1'b0;
        wr(A_A, 16'h0005);
        cyc(4);
        @(negedge clk); ext_pin_i[0] = 1'b1;
        cyc(2); rd(A_A, r); check("R2 not yet at 2 edges", {15'd0, r[15]}, 16'd0);
        cyc(1); rd(A_A, r); check("R2 set at 3 edges", {15'd0, r[15]}, 16'd1);

        // R5: writing 0 to the flag bit keeps it
        wr(A_A, 16'h0005);
        rd(A_A, r); check("R5 write 0 keeps flag", {15'd0, r[15]}, 16'd1);

        // R6: clear and new edge in the same cycle
        ext_pin_i[0] = 1'b0;
        cyc(5);
        @(negedge clk); ext_pin_i[0] = 1'b1;
        cyc(2);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = A_A; bus_wdata_i = 16'h8005;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
        rd(A_A, r); check("R6 set wins over clear", {15'd0, r[15]}, 16'd1);
        wr(A_A, 16'h8005);
        rd(A_A, r); check("R5 clear works", {15'd0, r[15]}, 16'd0);

        // R3: masked pending, then enable
        ext_pin_i[0] = 1'b0;
        wr(A_A, 16'h0004);
        cyc(4);
        ext_pin_i[0] = 1'b1;
        cyc(5);
        check("R3 masked no request", {15'd0, irq_hi_o}, 16'd0);
        wr(A_A, 16'h0005);
        check("R3 enable raises request", {15'd0, irq_hi_o}, 16'd1);
        wr(A_A, 16'h8005);

        // R7: gpio mode outputs and pin readback
        wr(A_B, 16'h0038);
        check("R7 gpio oe/out", {14'd0, gpio_oe_o[1], gpio_out_o[1]}, 16'd3);
        ext_pin_i[1] = 1'b1;
        cyc(3);
        rd(A_B, r); check("R7 pin read bit6", r, 16'h0078);
        check("R7 gpio no request", {14'd0, irq_hi_o, irq_lo_o}, 16'd0);
        ext_pin_i[1] = 1'b0;
        cyc(3);
        wr(A_B, 16'h0000);

        // R8: NMI pulse, unaffected by register writes
        wr(A_A, 16'h0000);
        @(negedge clk); nmi_i = 1'b1;
        cyc(2); check("R8 nmi not yet", {15'd0, nmi_req_o}, 16'd0);
        cyc(1); check("R8 nmi pulse", {15'd0, nmi_req_o}, 16'd1);
        cyc(1); check("R8 nmi one cycle", {15'd0, nmi_req_o}, 16'd0);
        nmi_i = 1'b0;

        // R9: protection, masked then enabled
        wr(A_P, 16'h0000);
        @(negedge clk); prot_i = 1'b1;
        cyc(3);
        check("R9 hiz while masked", {14'd0, drv_hiz_o, irq_hi_o}, 16'd2);
        rd(A_P, r); check("R9 flag bit1", r, 16'h0002);
        wr(A_P, 16'h0001);
        check("R9 enabled request", {15'd0, irq_hi_o}, 16'd1);

        // R10: hiz latched after input falls
        prot_i = 1'b0;
        cyc(6);
        check("R10 hiz held", {15'd0, drv_hiz_o}, 16'd1);
        wr(A_P, 16'h0003);
        check("R10 hiz released", {15'd0, drv_hiz_o}, 16'd0);

        // R11: two low-level sources share irq_lo
        ext_pin_i = 2'b00;
        wr(A_A, 16'h0007);
        wr(A_B, 16'h0007);
        cyc(3);
        ext_pin_i = 2'b11;
        cyc(5);
        check("R11 both pending", {15'd0, irq_lo_o}, 16'd1);
        wr(A_A, 16'h8007);
        check("R11 still high after one clear", {15'd0, irq_lo_o}, 16'd1);
        wr(A_B, 16'h8007);
        check("R11 low after all cleared", {15'd0, irq_lo_o}, 16'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule